// File: doc/BRIEF.md
# Nested Priority Interrupt Controller with Two-Level Cascade

The block watches eight active-high request lines, picks the most urgent pending line and raises one interrupt output toward the processor. When the processor acknowledges, the block presents an 8-bit vector for that line on a data bus for one cycle, so the processor can branch to the correct handler. While a handler runs, its line is recorded as in service. Only a line of strictly higher priority can interrupt again until an end-of-interrupt strobe retires that service.

Two instances can be chained to serve 15 request lines. A slave's interrupt output feeds request line 2 of a master. When the master acknowledges line 2, it leaves the data bus alone and instead enables the slave, and the slave then supplies the vector for its own winning line. A role parameter selects standalone, master or slave behaviour.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, intOut, vecDrive and casSel are all low.
- R2: A request held on a line with nothing in service raises intOut on the second rising clock edge after the request appears: one edge samples the line and the next registers the output.
- R3: When several lines are pending, the line with the lowest index wins. Line 0 has the highest priority and line 7 the lowest.
- R4: An accepted acknowledge makes vecDrive high for exactly the next cycle. In that cycle vecOut equals {vecBase[4:0], line[2:0]}, with the line number in bits 2:0 and the base in bits 7:3.
- R5: Once raised, intOut stays high until an accepted acknowledge, even if the request is withdrawn. It falls on the acknowledge edge and is re-evaluated on the following edge.
- R6: A line that is in service blocks itself and every lower-priority line. A higher-priority request still raises intOut and is acknowledged, so handlers nest.
- R7: An eoi pulse clears only the highest-priority in-service line. Lower-priority lines that are still in service keep blocking.
- R8: In the master role, acknowledging line 2 drives casSel high during the acknowledge cycle, and the master keeps vecDrive low.
- R9: In the slave role, an acknowledge is accepted only while casEn is high. The slave then drives its own vector, built from its own base.
- R10: In the slave role, an acknowledge with casEn low has no effect: the slave's intOut stays high and its vecDrive stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 8 | Request lines, active high |
| vecBase | input | 5 | Upper vector bits |
| intAck | input | 1 | Processor acknowledge, one-cycle pulse |
| eoi | input | 1 | End-of-interrupt pulse |
| casEn | input | 1 | Slave only: acknowledge enable from the master's casSel |
| intOut | output | 1 | Interrupt request to the processor or to the master |
| casSel | output | 1 | Master only: hands the acknowledge to the slave |
| vecDrive | output | 1 | Data bus drive enable for vecOut |
| vecOut | output | 8 | Vector byte |

## Verification
The bench builds two instances with the default eight lines. One is set up as a master, and the other as a slave whose interrupt output feeds the master's line 2. With this pair the bench can reach the handover, where the master raises casSel and the slave supplies the vector. It can also reach the case where the slave sees an acknowledge that belongs to the master and must ignore it. The master's remaining seven lines behave exactly as a standalone controller, so the vector table and the nesting tests run on those lines.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    ROLE_SINGLE = 2'd0,
    ROLE_MASTER = 2'd1,
    ROLE_SLAVE  = 2'd2
  } picRole_e;

  // strobes issued by the control to the datapath
  typedef struct packed {
    logic latchWin;  // capture the current candidate as the winner
    logic takeAck;   // acknowledge accepted: mark in service, load vector
    logic clrTop;    // retire the highest-priority in-service line
  } picStrobe_t;
endpackage

// File: rtl/pic_prio_find.sv
module pic_prio_find #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  bits,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest set index wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = i[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int       NUM_LINES = 8,
  parameter int       VEC_W     = 8,
  parameter int       CAS_LINE  = 2,
  parameter picRole_e ROLE      = ROLE_SINGLE,
  localparam int      ID_W      = $clog2(NUM_LINES),
  localparam int      BASE_W    = VEC_W - ID_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqReq,
  input  logic [BASE_W-1:0]    vecBase,
  input  picStrobe_t           st,
  output logic                 candValid,
  output logic                 winIsCas,
  output logic [VEC_W-1:0]     vecOut
);
  logic [NUM_LINES-1:0] reqSample;
  logic [NUM_LINES-1:0] inService;
  logic [NUM_LINES-1:0] setMask;
  logic [NUM_LINES-1:0] clrMask;
  logic                 reqFound;
  logic                 svcFound;
  logic [ID_W-1:0]      reqIdx;
  logic [ID_W-1:0]      svcIdx;
  logic [ID_W-1:0]      winId;
  logic [VEC_W-1:0]     vecReg;

  pic_prio_find #(.N(NUM_LINES)) uReqFind (
    .bits (reqSample),
    .found(reqFound),
    .idx  (reqIdx)
  );

  pic_prio_find #(.N(NUM_LINES)) uSvcFind (
    .bits (inService),
    .found(svcFound),
    .idx  (svcIdx)
  );

  // a candidate must outrank every line already in service
  assign candValid = reqFound && (!svcFound || (reqIdx < svcIdx));

  generate
    if (ROLE == ROLE_MASTER) begin : gCas
      assign winIsCas = (winId == CAS_LINE[ID_W-1:0]);
    end else begin : gNoCas
      assign winIsCas = 1'b0;
    end
  endgenerate

  always_comb begin
    setMask = '0;
    clrMask = '0;
    if (st.takeAck)           setMask[winId]  = 1'b1;
    if (st.clrTop && svcFound) clrMask[svcIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqSample <= '0;
      inService <= '0;
      winId     <= '0;
      vecReg    <= '0;
    end else begin
      reqSample <= irqReq;
      inService <= (inService & ~clrMask) | setMask;
      if (st.latchWin) winId  <= reqIdx;
      if (st.takeAck)  vecReg <= {vecBase, winId};
    end
  end

  assign vecOut = vecReg;
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter picRole_e ROLE = ROLE_SINGLE
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       candValid,
  input  logic       winIsCas,
  input  logic       intAck,
  input  logic       casEn,
  input  logic       eoi,
  output picStrobe_t st,
  output logic       intOut,
  output logic       casSel,
  output logic       vecDrive
);
  logic intOutQ;
  logic driveQ;
  logic ackIn;
  logic take;

  generate
    if (ROLE == ROLE_SLAVE) begin : gSlaveAck
      assign ackIn = intAck && casEn;
    end else begin : gLocalAck
      assign ackIn = intAck;
    end
    if (ROLE == ROLE_MASTER) begin : gCasOut
      assign casSel = take && winIsCas;
    end else begin : gNoCasOut
      assign casSel = 1'b0;
    end
  endgenerate

  assign take = intOutQ && ackIn;

  always_comb begin
    st          = '0;
    st.latchWin = !intOutQ && candValid;
    st.takeAck  = take;
    st.clrTop   = eoi;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intOutQ <= 1'b0;
      driveQ  <= 1'b0;
    end else begin
      if (take)         intOutQ <= 1'b0;
      else if (!intOutQ) intOutQ <= candValid;
      driveQ <= take && !winIsCas;
    end
  end

  assign intOut   = intOutQ;
  assign vecDrive = driveQ;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int       NUM_LINES = 8,
  parameter int       VEC_W     = 8,
  parameter int       CAS_LINE  = 2,
  parameter picRole_e ROLE      = ROLE_SINGLE,
  localparam int      ID_W      = $clog2(NUM_LINES),
  localparam int      BASE_W    = VEC_W - ID_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqReq,
  input  logic [BASE_W-1:0]    vecBase,
  input  logic                 intAck,
  input  logic                 eoi,
  input  logic                 casEn,
  output logic                 intOut,
  output logic                 casSel,
  output logic                 vecDrive,
  output logic [VEC_W-1:0]     vecOut
);
  picStrobe_t st;
  logic       candValid;
  logic       winIsCas;

  pic_ctrl #(.ROLE(ROLE)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .candValid(candValid),
    .winIsCas (winIsCas),
    .intAck   (intAck),
    .casEn    (casEn),
    .eoi      (eoi),
    .st       (st),
    .intOut   (intOut),
    .casSel   (casSel),
    .vecDrive (vecDrive)
  );

  pic_datapath #(
    .NUM_LINES(NUM_LINES),
    .VEC_W    (VEC_W),
    .CAS_LINE (CAS_LINE),
    .ROLE     (ROLE)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .irqReq   (irqReq),
    .vecBase  (vecBase),
    .st       (st),
    .candValid(candValid),
    .winIsCas (winIsCas),
    .vecOut   (vecOut)
  );
endmodule

// File: rtl/pic_chk.sv
module pic_chk
  import pic_pkg::*;
#(
  parameter picRole_e ROLE = ROLE_SINGLE
) (
  input logic clk,
  input logic rstN,
  input logic intAck,
  input logic casEn,
  input logic intOut,
  input logic casSel,
  input logic vecDrive
);
  logic ackOk;
  assign ackOk = (ROLE != ROLE_SLAVE) || casEn;

  // R5
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intOut && !(intAck && ackOk)) |=> intOut);

  // R5
  drop_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intOut && intAck && ackOk) |=> !intOut);

  // R4
  vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecDrive |-> $past(intOut && intAck && ackOk));

  // R4
  vec_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecDrive |=> !vecDrive);

  // R8
  cas_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    casSel |=> !vecDrive);
endmodule

bind prio_irq_ctrl pic_chk #(.ROLE(ROLE)) uPicChk (
  .clk     (clk),
  .rstN    (rstN),
  .intAck  (intAck),
  .casEn   (casEn),
  .intOut  (intOut),
  .casSel  (casSel),
  .vecDrive(vecDrive)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  import pic_pkg::*;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] mReq;
  logic [7:0] sReq;
  logic [4:0] mBase;
  logic [4:0] sBase;
  logic       intAck;
  logic       mEoi;
  logic       sEoi;
  logic       mInt, sInt, mCas, sCas, mDrv, sDrv;
  logic [7:0] mVec, sVec;
  logic [7:0] mLines;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign mLines = {mReq[7:3], sInt, mReq[1:0]};

  prio_irq_ctrl #(.ROLE(ROLE_MASTER)) u0 (
    .clk(clk), .rstN(rstN), .irqReq(mLines), .vecBase(mBase),
    .intAck(intAck), .eoi(mEoi), .casEn(1'b0),
    .intOut(mInt), .casSel(mCas), .vecDrive(mDrv), .vecOut(mVec)
  );

  prio_irq_ctrl #(.ROLE(ROLE_SLAVE)) u1 (
    .clk(clk), .rstN(rstN), .irqReq(sReq), .vecBase(sBase),
    .intAck(intAck), .eoi(sEoi), .casEn(mCas),
    .intOut(sInt), .casSel(sCas), .vecDrive(sDrv), .vecOut(sVec)
  );

  // entry: {line[2:0], base[4:0]}
  localparam logic [7:0] VEC_TAB [7] = '{
    {3'd0, 5'h01}, {3'd1, 5'h1F}, {3'd3, 5'h0A}, {3'd4, 5'h15},
    {3'd5, 5'h00}, {3'd6, 5'h12}, {3'd7, 5'h07}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic mAck();
    intAck = 1'b1;
    tick();
    intAck = 1'b0;
  endtask

  task automatic mEoiPulse();
    mEoi = 1'b1;
    tick();
    mEoi = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; mReq = '0; sReq = '0; mBase = 5'h10; sBase = 5'h08;
    intAck = 1'b0; mEoi = 1'b0; sEoi = 1'b0;
    tick(3);
    // R1 reset state
    chk("R1 intOut", {7'd0, mInt}, 8'd0);
    chk("R1 vecDrive", {7'd0, mDrv}, 8'd0);
    chk("R1 casSel", {7'd0, mCas}, 8'd0);
    rstN = 1'b1;
    tick(2);

    // vector table walk: R2 and R4 per line
    for (int k = 0; k < 7; k++) begin
      mBase = VEC_TAB[k][4:0];
      mReq  = 8'd1 << VEC_TAB[k][7:5];
      tick();
      chk("R2 not yet", {7'd0, mInt}, 8'd0);
      tick();
      chk("R2 intOut", {7'd0, mInt}, 8'd1);
      mAck();
      chk("R4 vecDrive", {7'd0, mDrv}, 8'd1);
      chk("R4 vecOut", mVec, {VEC_TAB[k][4:0], VEC_TAB[k][7:5]});
      chk("R5 drop", {7'd0, mInt}, 8'd0);
      mReq = '0;
      tick();
      chk("R4 pulse", {7'd0, mDrv}, 8'd0);
      mEoiPulse();
      tick(2);
    end
    mBase = 5'h10;

    // R3: lines 7 and 5 together, 5 first
    mReq = 8'hA0;
    tick(2);
    chk("R3 intOut", {7'd0, mInt}, 8'd1);
    mAck();
    chk("R3 first", mVec, {5'h10, 3'd5});
    mReq = 8'h80;
    mEoiPulse();
    tick(2);
    chk("R3 next intOut", {7'd0, mInt}, 8'd1);
    mAck();
    chk("R3 second", mVec, {5'h10, 3'd7});
    mReq = '0;
    mEoiPulse();
    tick(2);

    // R5: hold after request withdrawn
    mReq = 8'h08;
    tick(2);
    mReq = '0;
    tick(3);
    chk("R5 held", {7'd0, mInt}, 8'd1);
    mAck();
    chk("R5 fell", {7'd0, mInt}, 8'd0);
    chk("R5 vec", mVec, {5'h10, 3'd3});
    tick(2);
    chk("R5 re-eval", {7'd0, mInt}, 8'd0);
    mEoiPulse();
    tick(2);

    // R6 / R7 nesting
    mReq = 8'h10;
    tick(2);
    mAck();
    chk("R6 line4", mVec, {5'h10, 3'd4});
    mReq = 8'h42;          // lines 6 and 1
    tick(2);
    chk("R6 preempt intOut", {7'd0, mInt}, 8'd1);
    mAck();
    chk("R6 line1", mVec, {5'h10, 3'd1});
    mReq = 8'h40;
    tick(3);
    chk("R6 line6 blocked", {7'd0, mInt}, 8'd0);
    mEoiPulse();           // retires line 1 only
    tick(3);
    chk("R7 line4 still blocks", {7'd0, mInt}, 8'd0);
    mEoiPulse();           // retires line 4
    tick(2);
    chk("R7 line6 released", {7'd0, mInt}, 8'd1);
    mAck();
    chk("R7 line6 vec", mVec, {5'h10, 3'd6});
    mReq = '0;
    mEoiPulse();
    tick(2);

    // cascade: master line 0 and slave line 5 together
    mReq = 8'h01;
    sReq = 8'h20;
    tick(2);
    chk("R2 slave intOut", {7'd0, sInt}, 8'd1);
    mAck();
    chk("R10 master vec", mVec, {5'h10, 3'd0});
    chk("R10 slave no drive", {7'd0, sDrv}, 8'd0);
    chk("R10 slave held", {7'd0, sInt}, 8'd1);
    mReq = '0;
    mEoiPulse();
    tick();
    chk("R8 cascade intOut", {7'd0, mInt}, 8'd1);
    intAck = 1'b1;
    #1;
    chk("R8 casSel", {7'd0, mCas}, 8'd1);
    tick();
    intAck = 1'b0;
    chk("R8 master no drive", {7'd0, mDrv}, 8'd0);
    chk("R9 slave drive", {7'd0, sDrv}, 8'd1);
    chk("R9 slave vec", sVec, {5'h08, 3'd5});
    chk("R9 slave dropped", {7'd0, sInt}, 8'd0);
    sReq = '0;
    mEoi = 1'b1; sEoi = 1'b1;
    tick();
    mEoi = 1'b0; sEoi = 1'b0;
    tick(3);
    chk("R8 idle", {7'd0, mInt}, 8'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule